// File: doc/BRIEF.md
# Asynchronous Static RAM Access Controller

This block lets a clocked host read and write a 1M-word by 16-bit asynchronous static RAM. On the host side there is a single request channel with valid/ready, an address, a write flag, a two-bit lane mask and write data. Completion is reported by a one-cycle done pulse, and read data is returned with that pulse. On the memory side the block drives the word address, the two chip selects (one active low, one active high), write strobe, output enable, and the two active-low byte-lane enables. It also drives the outbound data word together with a tristate enable that the pad ring uses to resolve the bidirectional bus.

The RAM has no clock, so every minimum time it imposes is turned into a whole number of controller clocks. Each count is a module parameter, set to the ceiling of the nanosecond limit divided by the clock period, and no phase is shorter than one cycle. A read holds its strobes for the longer of the full access limit and the output-enable limit, and samples the bus on the closing edge of that window. The read is then followed by a quiet gap that gives the RAM time to release the bus. A write holds the strobe for the longest of the cycle, pulse-width and data-setup limits, and drives the data for the whole pulse.

Top module: `asram_ctrl`

## Requirements
- R1: After reset both chip selects are inactive (mem_cs1_no=1, mem_cs2_o=0), mem_we_no=1, mem_oe_no=1, both lane enables are 1, mem_dq_oe_o=0, req_ready_o=1 and rsp_done_o=0.
- R2: A write asserts the chip selects and mem_we_no=0, with mem_oe_no=1 and mem_dq_oe_o=1, for exactly max(WR_CYC, WP_CYC, DW_CYC) cycles. mem_dq_o is held constant for the whole strobe. rsp_done_o rises that many cycles after the accepting edge. mem_we_no is never low unless the chip is selected.
- R3: Mask bit 0 selects the low lane (data bits 7:0, mem_lb_no=0) and mask bit 1 selects the high lane (bits 15:8, mem_ub_no=0). A write changes only the selected lanes of the stored word.
- R4: A read asserts the chip selects with mem_oe_no=0, mem_we_no=1 and mem_dq_oe_o=0 for exactly max(RD_CYC, OE_CYC) cycles. The bus is sampled on the edge that closes this window. rsp_done_o is a single-cycle pulse that rises that many cycles after the accepting edge, with the read word on rsp_rdata_o.
- R5: After a read, all strobes stay inactive and mem_dq_oe_o stays 0 for TURN_CYC cycles before req_ready_o returns. The controller never drives the bus while the RAM may still be driving it.
- R6: req_ready_o is 1 only while idle. A request is taken on a clock edge where req_valid_i and req_ready_o are both 1. req_ready_o is 0 from the cycle after acceptance until the access completes.
- R7: mem_addr_o shows the accepted address from the first selected cycle, and does not change while the chip stays selected.
- R8: A request with mask 2'b00 keeps both lane enables at 1, so the RAM stays in standby. Stored data is unchanged, and the request still completes with a done pulse after the normal phase length.
- R9: mem_we_no and mem_oe_no are never low together, and mem_dq_oe_o is never 1 while mem_oe_no is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Controller clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Host request present |
| req_ready_o | output | 1 | Controller idle and able to take a request |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | ADDR_W | Word address |
| req_be_i | input | 2 | Lane mask, bit 0 low byte, bit 1 high byte |
| req_wdata_i | input | 16 | Write data |
| rsp_done_o | output | 1 | One-cycle completion pulse |
| rsp_rdata_o | output | 16 | Read data, valid with the done pulse of a read |
| mem_addr_o | output | ADDR_W | RAM word address |
| mem_cs1_no | output | 1 | Chip select, active low |
| mem_cs2_o | output | 1 | Chip select, active high |
| mem_we_no | output | 1 | Write strobe, active low |
| mem_oe_no | output | 1 | Output enable, active low |
| mem_lb_no | output | 1 | Low-lane enable, active low |
| mem_ub_no | output | 1 | High-lane enable, active low |
| mem_dq_o | output | 16 | Data toward the RAM |
| mem_dq_oe_o | output | 1 | Tristate enable for mem_dq_o |
| mem_dq_i | input | 16 | Data from the RAM bus |

## Verification
The main function is exercised in several ways: full-word writes and reads, single-lane writes over words already filled, empty-mask requests, accesses at the lowest and highest addresses, back-to-back writes, and a read followed at once by a write. Single-lane writes over known contents show that the lane enables reach the right byte. Empty masks show the difference between a standby access and a skipped one. The read-then-write pair exposes a missing or short bus turnaround. The RAM model in the bench returns a garbage pattern until the read window has lasted its programmed minimum, so sampling one cycle early appears as wrong data. The model also rejects any write strobe or data-stable span shorter than its minimum.

// File: rtl/asram_pkg.sv
package asram_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WRITE = 2'd1,
    ST_READ  = 2'd2,
    ST_TURN  = 2'd3
  } asram_st_e;

  function automatic int unsigned umax(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/asram_timer.sv
// Down-counter for phase lengths; zero_o marks the last cycle of a phase.
module asram_timer #(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             zero_o
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (load_i)         cnt_q <= load_val_i;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/asram_dpath.sv
// Address, write data and read capture registers.
module asram_dpath #(
  parameter int unsigned ADDR_W = 20,
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              accept_i,
  input  logic              capture_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [DATA_W-1:0] bus_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] wdata_o,
  output logic [DATA_W-1:0] rdata_o
);

  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [DATA_W-1:0] rdata_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (accept_i) begin
      addr_q  <= addr_i;
      wdata_q <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        rdata_q <= '0;
    else if (capture_i) rdata_q <= bus_i;
  end

  assign addr_o  = addr_q;
  assign wdata_o = wdata_q;
  assign rdata_o = rdata_q;

endmodule

// File: rtl/asram_seq.sv
// Phase sequencer; all memory strobes leave this module from flops.
module asram_seq
  import asram_pkg::*;
#(
  parameter int unsigned LANES    = 2,
  parameter int unsigned RD_LEN   = 6,
  parameter int unsigned WR_LEN   = 6,
  parameter int unsigned TURN_LEN = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic             write_i,
  input  logic [LANES-1:0] be_i,
  output logic             ready_o,
  output logic             accept_o,
  output logic             capture_o,
  output logic             done_o,
  output logic             sel_o,
  output logic             we_o,
  output logic             oe_o,
  output logic [LANES-1:0] lane_o,
  output logic             drv_o
);

  localparam int unsigned MAX_LEN = umax(umax(RD_LEN, WR_LEN), TURN_LEN);
  localparam int unsigned CNT_W   = $clog2(MAX_LEN + 1);
  localparam logic [CNT_W-1:0] RD_LOAD   = CNT_W'(RD_LEN - 1);
  localparam logic [CNT_W-1:0] WR_LOAD   = CNT_W'(WR_LEN - 1);
  localparam logic [CNT_W-1:0] TURN_LOAD = CNT_W'(TURN_LEN - 1);

  asram_st_e        st_q, st_d;
  logic             tmr_load, tmr_zero;
  logic [CNT_W-1:0] tmr_val;
  logic [LANES-1:0] be_q, be_d;
  logic             accept, capture, fin_d;

  logic             sel_q, we_q, oe_q, drv_q, done_q;
  logic [LANES-1:0] lane_q;

  asram_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (tmr_load),
    .load_val_i (tmr_val),
    .zero_o     (tmr_zero)
  );

  always_comb begin
    st_d     = st_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    accept   = 1'b0;
    capture  = 1'b0;
    fin_d    = 1'b0;
    unique case (st_q)
      ST_IDLE: if (valid_i) begin
        accept   = 1'b1;
        tmr_load = 1'b1;
        st_d     = write_i ? ST_WRITE : ST_READ;
        tmr_val  = write_i ? WR_LOAD : RD_LOAD;
      end
      ST_WRITE: if (tmr_zero) begin
        st_d  = ST_IDLE;
        fin_d = 1'b1;
      end
      ST_READ: if (tmr_zero) begin
        capture  = 1'b1;
        fin_d    = 1'b1;
        tmr_load = 1'b1;
        tmr_val  = TURN_LOAD;
        st_d     = ST_TURN;
      end
      ST_TURN: if (tmr_zero) st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  assign be_d = accept ? be_i : be_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      be_q   <= '0;
      sel_q  <= 1'b0;
      we_q   <= 1'b0;
      oe_q   <= 1'b0;
      drv_q  <= 1'b0;
      lane_q <= '0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      be_q   <= be_d;
      sel_q  <= (st_d == ST_WRITE) || (st_d == ST_READ);
      we_q   <= (st_d == ST_WRITE);
      oe_q   <= (st_d == ST_READ);
      drv_q  <= (st_d == ST_WRITE);
      lane_q <= ((st_d == ST_WRITE) || (st_d == ST_READ)) ? be_d : '0;
      done_q <= fin_d;
    end
  end

  assign ready_o   = (st_q == ST_IDLE);
  assign accept_o  = accept;
  assign capture_o = capture;
  assign done_o    = done_q;
  assign sel_o     = sel_q;
  assign we_o      = we_q;
  assign oe_o      = oe_q;
  assign lane_o    = lane_q;
  assign drv_o     = drv_q;

  assert_we_oe_excl_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(we_q && oe_q));
  assert_no_drive_on_read_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drv_q |-> !oe_q);
  assert_done_pulse_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q);
  assert_busy_after_accept_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> !ready_o);
  assert_turn_quiet_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(oe_q) |-> (!drv_q && !sel_q && !ready_o));
  assert_lanes_stable_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_q && $past(sel_q)) |-> $stable(lane_q));

endmodule

// File: rtl/asram_ctrl.sv
module asram_ctrl #(
  parameter int unsigned ADDR_W   = 20,
  parameter int unsigned RD_CYC   = 6,
  parameter int unsigned OE_CYC   = 3,
  parameter int unsigned WR_CYC   = 6,
  parameter int unsigned WP_CYC   = 4,
  parameter int unsigned DW_CYC   = 3,
  parameter int unsigned TURN_CYC = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_write_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [1:0]        req_be_i,
  input  logic [15:0]       req_wdata_i,
  output logic              rsp_done_o,
  output logic [15:0]       rsp_rdata_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_cs1_no,
  output logic              mem_cs2_o,
  output logic              mem_we_no,
  output logic              mem_oe_no,
  output logic              mem_lb_no,
  output logic              mem_ub_no,
  output logic [15:0]       mem_dq_o,
  output logic              mem_dq_oe_o,
  input  logic [15:0]       mem_dq_i
);
  import asram_pkg::*;

  localparam int unsigned DATA_W   = 16;
  localparam int unsigned LANES    = DATA_W / 8;
  localparam int unsigned RD_LEN   = umax(umax(RD_CYC, OE_CYC), 1);
  localparam int unsigned WR_LEN   = umax(umax(WR_CYC, WP_CYC), umax(DW_CYC, 1));
  localparam int unsigned TURN_LEN = umax(TURN_CYC, 1);

  logic             accept, capture;
  logic             sel, we, oe, drv;
  logic [LANES-1:0] lane;

  asram_seq #(
    .LANES    (LANES),
    .RD_LEN   (RD_LEN),
    .WR_LEN   (WR_LEN),
    .TURN_LEN (TURN_LEN)
  ) u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .valid_i   (req_valid_i),
    .write_i   (req_write_i),
    .be_i      (req_be_i),
    .ready_o   (req_ready_o),
    .accept_o  (accept),
    .capture_o (capture),
    .done_o    (rsp_done_o),
    .sel_o     (sel),
    .we_o      (we),
    .oe_o      (oe),
    .lane_o    (lane),
    .drv_o     (drv)
  );

  asram_dpath #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_dpath (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .accept_i  (accept),
    .capture_i (capture),
    .addr_i    (req_addr_i),
    .wdata_i   (req_wdata_i),
    .bus_i     (mem_dq_i),
    .addr_o    (mem_addr_o),
    .wdata_o   (mem_dq_o),
    .rdata_o   (rsp_rdata_o)
  );

  assign mem_cs1_no  = ~sel;
  assign mem_cs2_o   = sel;
  assign mem_we_no   = ~we;
  assign mem_oe_no   = ~oe;
  assign mem_lb_no   = ~lane[0];
  assign mem_ub_no   = ~lane[1];
  assign mem_dq_oe_o = drv;

  assert_addr_stable_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_cs2_o && $past(mem_cs2_o)) |-> $stable(mem_addr_o));
  assert_we_needs_sel_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_we_no |-> (!mem_cs1_no && mem_cs2_o));
  assert_wdata_stable_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mem_we_no && $past(!mem_we_no)) |-> $stable(mem_dq_o));

endmodule

// File: tb/asram_ctrl_test.sv
module asram_ctrl_test;

  localparam int RD = 6, OE = 3, WR = 6, WP = 4, DW = 3, TN = 2;
  localparam int RD_LEN = (RD > OE) ? RD : OE;
  localparam int WR_LEN = (WR > WP) ? ((WR > DW) ? WR : DW) : ((WP > DW) ? WP : DW);
  localparam logic [15:0] JUNK = 16'hBAD0;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [19:0] req_addr = '0;
  logic [1:0]  req_be = '0;
  logic [15:0] req_wdata = '0;
  logic        ready, done, cs1_n, cs2, we_n, oe_n, lb_n, ub_n, dq_oe;
  logic [15:0] rdata, dq_o;
  logic [15:0] ram_dq = JUNK;
  logic [19:0] maddr;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  asram_ctrl #(.ADDR_W(20), .RD_CYC(RD), .OE_CYC(OE), .WR_CYC(WR), .WP_CYC(WP),
               .DW_CYC(DW), .TURN_CYC(TN)) uut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_ready_o(ready),
    .req_write_i(req_write), .req_addr_i(req_addr), .req_be_i(req_be),
    .req_wdata_i(req_wdata), .rsp_done_o(done), .rsp_rdata_o(rdata),
    .mem_addr_o(maddr), .mem_cs1_no(cs1_n), .mem_cs2_o(cs2), .mem_we_no(we_n),
    .mem_oe_no(oe_n), .mem_lb_no(lb_n), .mem_ub_no(ub_n), .mem_dq_o(dq_o),
    .mem_dq_oe_o(dq_oe), .mem_dq_i(ram_dq));

  task automatic chk(input string req, input bit ok, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural RAM model and bench-side reference
  logic [15:0] mdl [int];
  logic [15:0] refm [int];
  int wcnt = 0, dstab = 0, rcnt = 0, hold = 0;
  logic [15:0] w_data;
  logic [19:0] w_addr, r_addr;
  logic [1:0]  w_lanes;

  function automatic logic [15:0] rd_mem(input int a);
    return mdl.exists(a) ? mdl[a] : 16'h0000;
  endfunction

  always @(negedge clk) if (rst_n) begin
    automatic bit sel = !cs1_n && cs2 && !(ub_n && lb_n);
    automatic bit wr  = sel && !we_n;
    automatic bit rd  = sel && we_n && !oe_n;
    chk("R9 we/oe overlap", !(!we_n && !oe_n), {we_n, oe_n}, 2'b11);
    chk("R9 drive while oe", !(dq_oe && !oe_n), dq_oe, 0);
    if (wr) begin
      if (wcnt == 0 || dq_o != w_data || maddr != w_addr) dstab = 1; else dstab++;
      w_data = dq_o; w_addr = maddr; w_lanes = {!ub_n, !lb_n};
      wcnt++;
    end else if (wcnt != 0) begin
      chk("R2 write pulse length", wcnt >= WP && wcnt >= WR, wcnt, WR_LEN);
      chk("R2 data setup", dstab >= DW, dstab, DW);
      begin
        automatic logic [15:0] o = rd_mem(int'(w_addr));
        if (w_lanes[0]) o[7:0]  = w_data[7:0];
        if (w_lanes[1]) o[15:8] = w_data[15:8];
        mdl[int'(w_addr)] = o;
      end
      wcnt = 0;
    end
    if (rd) begin
      if (rcnt != 0 && maddr != r_addr) rcnt = 0;
      r_addr = maddr;
      rcnt++;
      if (rcnt >= RD && rcnt >= OE) begin
        ram_dq = rd_mem(int'(maddr));
        if (lb_n) ram_dq[7:0]  = JUNK[7:0];
        if (ub_n) ram_dq[15:8] = JUNK[15:8];
      end else ram_dq = JUNK;
    end else begin
      if (rcnt != 0) hold = TN;
      rcnt = 0;
      ram_dq = JUNK;
      if (hold > 0) begin
        chk("R5 bus contention after read", !dq_oe, dq_oe, 0);
        hold--;
      end
    end
  end

  task automatic access(input bit wr, input logic [19:0] a, input logic [1:0] be, input logic [15:0] d);
    int n;
    @(negedge clk);
    chk("R6 ready when idle", ready, ready, 1);
    req_valid = 1; req_write = wr; req_addr = a; req_be = be; req_wdata = d;
    @(negedge clk);
    req_valid = 0;
    chk("R6 busy after accept", !ready, ready, 0);
    chk("R7 address on bus", maddr == a && !cs1_n && cs2, {cs1_n, cs2, maddr}, {2'b01, a});
    chk("R3 lane enables", {ub_n, lb_n} == ~be, {ub_n, lb_n}, ~be);
    if (wr) chk("R2 strobes", !we_n && oe_n && dq_oe && dq_o == d, {we_n, oe_n, dq_oe, dq_o}, {3'b011, d});
    else    chk("R4 strobes", we_n && !oe_n && !dq_oe, {we_n, oe_n, dq_oe}, 3'b100);
    n = 0;
    while (!done && n < 100) begin @(negedge clk); n++; end
    if (wr) begin
      chk("R2 write latency", n == WR_LEN, n, WR_LEN);
      begin
        automatic logic [15:0] o = refm.exists(int'(a)) ? refm[int'(a)] : 16'h0;
        if (be[0]) o[7:0]  = d[7:0];
        if (be[1]) o[15:8] = d[15:8];
        refm[int'(a)] = o;
      end
    end else begin
      automatic logic [15:0] e = refm.exists(int'(a)) ? refm[int'(a)] : 16'h0;
      automatic logic [15:0] m = {{8{be[1]}}, {8{be[0]}}};
      chk("R4 read latency", n == RD_LEN, n, RD_LEN);
      chk("R4 read data", (rdata & m) == (e & m), rdata & m, e & m);
      n = 0;
      while (!ready && n < 100) begin @(negedge clk); n++; end
      chk("R5 turnaround length", n == TN, n, TN);
    end
    @(negedge clk);
    chk("R4 done single pulse", !done, done, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset strobes", {cs1_n, cs2, we_n, oe_n, lb_n, ub_n, dq_oe} == 7'b1011110,
        {cs1_n, cs2, we_n, oe_n, lb_n, ub_n, dq_oe}, 7'b1011110);
    chk("R1 reset handshake", ready && !done, {ready, done}, 2'b10);
    rst_n = 1;
    @(negedge clk);
    access(1, 20'h00010, 2'b11, 16'h1234);
    access(0, 20'h00010, 2'b11, 0);
    access(1, 20'h00010, 2'b01, 16'hAAEE);        // R3 low lane only
    access(0, 20'h00010, 2'b11, 0);
    access(1, 20'h00010, 2'b10, 16'h77BB);        // R3 high lane only
    access(0, 20'h00010, 2'b11, 0);
    access(1, 20'h00010, 2'b00, 16'hFFFF);        // R8 empty mask write
    access(0, 20'h00010, 2'b11, 0);
    access(0, 20'h00010, 2'b00, 0);               // R8 empty mask read
    access(1, 20'h00000, 2'b11, 16'h0F0F);
    access(1, 20'hFFFFF, 2'b11, 16'hF0F0);        // back-to-back writes
    access(0, 20'h00000, 2'b11, 0);
    access(1, 20'h00000, 2'b10, 16'hC3C3);        // read then write: R5
    access(0, 20'hFFFFF, 2'b01, 0);
    access(0, 20'h00000, 2'b11, 0);
    begin
      logic [19:0] lf = 20'h5A5A5;
      for (int i = 0; i < 24; i++) begin
        lf = {lf[18:0], lf[19] ^ lf[16]};
        access(1, {12'h0, lf[7:0]}, lf[9:8], lf[19:4]);
        access(0, {12'h0, lf[7:0]}, 2'b11, 0);
      end
    end
    repeat (4) @(negedge clk);
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule